// File: doc/BRIEF.md
# Byte Serial Peripheral Port (SPI Master/Slave)

This block is a byte-wide SPI port that a processor reaches through three registers: control, status and data. As a master it generates the serial clock from the system clock using one of four divide ratios. Writing a byte to the data register while idle sends that byte and receives one in return. As a slave it shifts on an external serial clock, but only while its select input is low. It releases its serial output whenever it is deselected.

Both sides use clock mode 0. The clock idles low, received data is sampled on the rising clock edge, and outgoing data changes on the falling edge. A control bit picks whether the most or least significant bit goes first. After the eighth bit the received byte is copied into a read buffer and a completion flag rises. A data write made while a byte is still shifting is discarded and raises a collision flag. Both flags are cleared together by a two-step handshake: first a read of the status register while a flag is set, then any access to the data register.

Top module: `spi_port`

## Requirements
- R1: After reset the control, status and data registers all read 0. The outputs sck_o, sck_oe and miso_oe are all 0.
- R2: The register select encoding is 0 for control, 1 for status and 2 for data. Control bits are: bit 0 enable, bit 1 master, bit 2 least-significant-bit first, bits 4:3 rate. The control register reads back the whole byte last written. Status bit 7 is the completion flag and status bit 6 is the collision flag; the other status bits read 0.
- R3: In master mode with enable set, a data write while idle starts one 8-bit transfer. sck_o idles low. mosi_o changes after falling edges. miso_i is sampled on rising edges. sck_oe is high.
- R4: In master mode each sck_o high phase lasts 2, 8, 32 or 64 system clocks for rate 0, 1, 2 or 3 (divide by 4, 16, 64, 128).
- R5: With bit 2 clear the byte is sent and received most significant bit first; with it set, least significant bit first.
- R6: When the eighth bit has been shifted, the completion flag sets. The received byte then reads from the data register.
- R7: A data write during an active transfer sets the collision flag. The write is discarded: the byte in flight is sent unchanged.
- R8: A status read taken while a flag is set, followed by any data register access, clears both flags. A data access without such a prior read leaves the flags set. A status read taken while both flags are clear does not arm the clear.
- R9: In slave mode the port shifts on sck_i only while ss_n_i is low. miso_oe is high only while ss_n_i is low. Clock edges while ss_n_i is high change neither the flags nor the data register.
- R10: Clearing the enable bit aborts any transfer. sck_o returns low and sck_oe drops, no completion flag is raised, and data writes then start nothing. Re-enabling gives a working port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select (0 control, 1 status, 2 data) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on flags) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe | output | 1 | Slave data output enable |
| ss_n_i | input | 1 | Slave select, active low |

## Verification
The bench walks each rate in both bit orders against a modelled partner. A port that mirrored the bit order, or that divided by the wrong ratio, would show a wrong byte or a wrong high-phase length. A collision write lands mid-transfer: a port that accepted it would corrupt the byte in flight, and one that lost the flag would report a clean status. The clear handshake is driven both correctly and out of order, so flags that cleared on a data access alone, or on a status read of a clear register, are caught. The slave tests toggle the clock while deselected and drop enable mid-byte, which exposes a port that keeps shifting or finishes an aborted transfer.

// File: rtl/spi_port_pkg.sv
// Package spi_port_pkg
// Shared register encodings, control bit positions and the divider table
// for the SPI port. Assumes a byte-wide register interface.
package spi_port_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2
    } reg_sel_e;

    localparam int CTL_EN     = 0;
    localparam int CTL_MSTR   = 1;
    localparam int CTL_LSBF   = 2;
    localparam int CTL_RATE   = 3;
    localparam int STAT_DONE  = 7;
    localparam int STAT_COLL  = 6;

    localparam int MAX_HALF   = 64;
    localparam int DIV_W      = $clog2(MAX_HALF) + 1;

    // System clocks per serial clock phase for each rate code
    function automatic logic [DIV_W-1:0] half_cycles(input logic [1:0] rate);
        logic [DIV_W-1:0] h;
        unique case (rate)
            2'd0:    h = DIV_W'(2);
            2'd1:    h = DIV_W'(8);
            2'd2:    h = DIV_W'(32);
            default: h = DIV_W'(MAX_HALF);
        endcase
        return h;
    endfunction

endpackage

// File: rtl/spi_clkgen.sv
// Module spi_clkgen
// Produces the serial clock and one-cycle edge pulses.
// Master: the clock is divided down while run is high.
// Slave: the external clock is synchronised and its edges are detected;
// those edges count only while slave_act is high.
// Assumes the external clock is slow against clk (several clocks per phase).
module spi_clkgen
    import spi_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       slave_act,
    input  logic [1:0] rate,
    input  logic       sck_in,
    output logic       sck_out,
    output logic       rise_p,
    output logic       fall_p
);

    logic [DIV_W-1:0] div_q;
    logic             sck_q;
    logic [2:0]       sync_q;
    logic [DIV_W-1:0] half;
    logic             tick;

    assign half = half_cycles(rate);
    assign tick = run && (div_q == half - DIV_W'(1));

    // Divider counter and master clock level; idles low when not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
            sck_q <= 1'b0;
        end else if (tick) begin
            div_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // Synchroniser chain for the external serial clock
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], sck_in};
    end

    assign sck_out = sck_q;
    assign rise_p  = run ? (tick & ~sck_q) : (slave_act & sync_q[1] & ~sync_q[2]);
    assign fall_p  = run ? (tick &  sck_q) : (slave_act & ~sync_q[1] & sync_q[2]);

    assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sck_out);

    assert_no_rise_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !slave_act) |-> !(rise_p || fall_p));

endmodule

// File: rtl/spi_shifter.sv
// Module spi_shifter
// Shift register with bit counter. On a rise pulse it samples the serial
// input; on a fall pulse it shifts that sample in, in the selected order.
// done_p marks the shift of the final bit, and next_word is the completed
// byte in that cycle. Assumes load is given only between bytes.
module spi_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              lsb_first,
    input  logic              serial_in,
    input  logic              rise_p,
    input  logic              fall_p,
    output logic              ser_out,
    output logic              done_p,
    output logic [DATA_W-1:0] next_word,
    output logic              mid_xfer
);

    localparam int CW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic              samp_q;
    logic [CW-1:0]     cnt_q;

    assign next_word = lsb_first ? {samp_q, sh_q[DATA_W-1:1]}
                                 : {sh_q[DATA_W-2:0], samp_q};
    assign ser_out   = lsb_first ? sh_q[0] : sh_q[DATA_W-1];
    assign done_p    = fall_p && !clear && (cnt_q == LAST);
    assign mid_xfer  = (cnt_q != '0);

    // Shift data: a load replaces the word, a fall shifts one bit
    always_ff @(posedge clk) begin
        if (!rst_n)                 sh_q <= '0;
        else if (load)              sh_q <= load_data;
        else if (fall_p && !clear)  sh_q <= next_word;
    end

    // Sample the incoming bit on each rise pulse
    always_ff @(posedge clk) begin
        if (!rst_n)      samp_q <= 1'b0;
        else if (rise_p) samp_q <= serial_in;
    end

    // Count shifted bits, wrapping after the last one
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (fall_p)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end

    assert_load_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (cnt_q == '0));

    assert_clear_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !mid_xfer);

endmodule

// File: rtl/spi_flags.sv
// Module spi_flags
// Completion and collision flags. Both clear together once a status read,
// taken while either flag was set, is followed by a data access. A set
// in the same cycle takes priority over a clear.
module spi_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic done_p,
    input  logic coll_p,
    input  logic stat_rd,
    input  logic data_acc,
    output logic done_flag,
    output logic coll_flag
);

    logic armed_q;
    logic clr;

    assign clr = data_acc && armed_q;

    // Arm on a status read that saw a flag; disarm on any data access
    always_ff @(posedge clk) begin
        if (!rst_n)        armed_q <= 1'b0;
        else if (stat_rd)  armed_q <= done_flag | coll_flag;
        else if (data_acc) armed_q <= 1'b0;
    end

    // Completion flag
    always_ff @(posedge clk) begin
        if (!rst_n)      done_flag <= 1'b0;
        else if (done_p) done_flag <= 1'b1;
        else if (clr)    done_flag <= 1'b0;
    end

    // Collision flag
    always_ff @(posedge clk) begin
        if (!rst_n)      coll_flag <= 1'b0;
        else if (coll_p) coll_flag <= 1'b1;
        else if (clr)    coll_flag <= 1'b0;
    end

    assert_done_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_p |=> done_flag);

    assert_clear_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_flag) |-> $past(data_acc));

    assert_coll_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_flag) |-> $past(coll_p));

endmodule

// File: rtl/spi_port.sv
// Module spi_port
// Top level of the SPI port: register file, master/slave steering, and the
// clock generator, shifter and flag units. Reads have no latency. A read
// strobe with reg_rd gives status side effects. Assumes one strobe at a time.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n_i
);

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rbuf_q;
    logic              busy_q;

    logic en, is_mstr, lsbf, slave_act;
    logic [1:0] rate;
    logic data_wr, data_acc, stat_rd, xfer_busy, coll_p, load, start, clear;
    logic ser_out, done_p, mid_xfer, rise_p, fall_p, sck_gen;
    logic done_flag, coll_flag;
    logic [DATA_W-1:0] next_word;

    assign en        = ctrl_q[CTL_EN];
    assign is_mstr   = ctrl_q[CTL_MSTR];
    assign lsbf      = ctrl_q[CTL_LSBF];
    assign rate      = ctrl_q[CTL_RATE +: 2];
    assign slave_act = en && !is_mstr && !ss_n_i;

    assign data_wr   = reg_wr && (reg_sel == REG_DATA);
    assign data_acc  = (reg_wr || reg_rd) && (reg_sel == REG_DATA);
    assign stat_rd   = reg_rd && (reg_sel == REG_STAT);
    assign xfer_busy = is_mstr ? busy_q : mid_xfer;
    assign coll_p    = data_wr && en && xfer_busy;
    assign load      = data_wr && !xfer_busy;
    assign start     = load && en && is_mstr;
    assign clear     = !en || (!is_mstr && ss_n_i);

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctrl_q <= '0;
        else if (reg_wr && reg_sel == REG_CTRL)  ctrl_q <= reg_wdata;
    end

    // Master transfer in progress
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !is_mstr) busy_q <= 1'b0;
        else if (start)                busy_q <= 1'b1;
        else if (done_p)               busy_q <= 1'b0;
    end

    // Receive buffer, loaded when the final bit has been shifted
    always_ff @(posedge clk) begin
        if (!rst_n)      rbuf_q <= '0;
        else if (done_p) rbuf_q <= next_word;
    end

    // Register read multiplexer
    always_comb begin
        unique case (reg_sel)
            REG_CTRL: reg_rdata = ctrl_q;
            REG_STAT: reg_rdata = {done_flag, coll_flag, {(DATA_W-2){1'b0}}};
            REG_DATA: reg_rdata = rbuf_q;
            default:  reg_rdata = '0;
        endcase
    end

    spi_clkgen u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy_q),
        .slave_act (slave_act),
        .rate      (rate),
        .sck_in    (sck_i),
        .sck_out   (sck_gen),
        .rise_p    (rise_p),
        .fall_p    (fall_p)
    );

    spi_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .load      (load),
        .load_data (reg_wdata),
        .lsb_first (lsbf),
        .serial_in (is_mstr ? miso_i : mosi_i),
        .rise_p    (rise_p),
        .fall_p    (fall_p),
        .ser_out   (ser_out),
        .done_p    (done_p),
        .next_word (next_word),
        .mid_xfer  (mid_xfer)
    );

    spi_flags u_flg (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_p    (done_p),
        .coll_p    (coll_p),
        .stat_rd   (stat_rd),
        .data_acc  (data_acc),
        .done_flag (done_flag),
        .coll_flag (coll_flag)
    );

    assign sck_o   = sck_gen;
    assign sck_oe  = en && is_mstr;
    assign mosi_o  = (en && is_mstr) ? ser_out : 1'b0;
    assign miso_o  = ser_out;
    assign miso_oe = slave_act;

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy_q && !sck_o));

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy_q);

    assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_n_i && !is_mstr) |=> $stable(rbuf_q));

endmodule

// File: tb/sim_spi_port.sv
// Bench for spi_port: a vector table of master transfers, then directed tests.
module sim_spi_port;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    logic       sck_i = 1'b0, sck_o, sck_oe;
    logic       mosi_i = 1'b0, mosi_o;
    logic       miso_i = 1'b0, miso_o, miso_oe;
    logic       ss_n_i = 1'b1;

    int checks = 0;
    int errors = 0;

    // partner model for master tests
    logic [7:0] sl_tx = 8'h00, sl_rx = 8'h00;
    logic       lsbf = 1'b0;
    int         sl_idx = 0;

    // {ctrl, master tx byte, partner tx byte}
    localparam logic [23:0] VEC [6] = '{
        {8'h03, 8'hA5, 8'h3C},
        {8'h07, 8'hC1, 8'h2E},
        {8'h0B, 8'h4D, 8'h71},
        {8'h17, 8'h1F, 8'hE4},
        {8'h1B, 8'h68, 8'h0F},
        {8'h1F, 8'hF0, 8'h35}
    };

    spi_port u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i),
        .mosi_o(mosi_o), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_n_i(ss_n_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge sck_o) begin
        if (lsbf) sl_rx = {mosi_o, sl_rx[7:1]};
        else      sl_rx = {sl_rx[6:0], mosi_o};
    end

    always @(negedge sck_o) begin
        sl_idx = sl_idx + 1;
        if (sl_idx < 8) miso_i = lsbf ? sl_tx[sl_idx] : sl_tx[7 - sl_idx];
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic preset(input logic [7:0] tx, input logic order);
        lsbf = order; sl_tx = tx; sl_idx = 0; sl_rx = 8'h00;
        miso_i = order ? tx[0] : tx[7];
    endtask

    task automatic wait_done(output logic [7:0] st);
        st = 8'h00;
        for (int k = 0; k < 3000; k++) begin
            rd(2'd1, st);
            if (st[7]) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] got;
        int n;
        ss_n_i = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 sck_oe", sck_oe, 0);
        chk("R1 miso_oe", miso_oe, 0);
        chk("R1 sck_o", sck_o, 0);
        rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd1, v); chk("R1 status", v, 8'h00);
        rd(2'd2, v); chk("R1 data", v, 8'h00);
        ss_n_i = 1'b1;

        // R2 control read-back
        wr(2'd0, 8'hE4); rd(2'd0, v); chk("R2 ctrl readback", v, 8'hE4);
        wr(2'd0, 8'h00);

        // table walk: R3 R4 R5 R6 R8
        foreach (VEC[i]) begin
            logic [7:0] c, tx, px;
            int exp_half;
            {c, tx, px} = VEC[i];
            case (c[4:3])
                2'd0: exp_half = 2;
                2'd1: exp_half = 8;
                2'd2: exp_half = 32;
                default: exp_half = 64;
            endcase
            wr(2'd0, c);
            preset(px, c[2]);
            wr(2'd2, tx);
            chk("R3 sck_oe master", sck_oe, 1);
            @(posedge sck_o);
            n = 0;
            do begin
                @(posedge clk); #1; n++;
            end while (sck_o);
            chk("R4 high phase", n, exp_half);
            wait_done(v);
            chk("R6 done flag", v, 8'h80);
            chk("R5 partner received", sl_rx, tx);
            rd(2'd2, v); chk("R6 R5 received byte", v, px);
            rd(2'd1, v); chk("R8 cleared", v, 8'h00);
            chk("R3 sck idle low", sck_o, 0);
        end

        // R7 collision
        wr(2'd0, 8'h1B);
        preset(8'h55, 1'b0);
        wr(2'd2, 8'hA5);
        tick(100);
        wr(2'd2, 8'h3C);
        tick(1200);
        rd(2'd1, v); chk("R7 both flags", v, 8'hC0);
        chk("R7 byte in flight unchanged", sl_rx, 8'hA5);
        rd(2'd2, v); chk("R7 received byte", v, 8'h55);
        rd(2'd1, v); chk("R8 both cleared", v, 8'h00);

        // R8 out-of-order access leaves flags; clear-status read does not arm
        rd(2'd1, v);
        preset(8'h77, 1'b0);
        wr(2'd2, 8'h12);
        tick(1200);
        rd(2'd2, v); chk("R8 data without arm", v, 8'h77);
        rd(2'd1, v); chk("R8 flag kept", v, 8'h80);
        rd(2'd2, v);
        rd(2'd1, v); chk("R8 clear after arm", v, 8'h00);

        // R9 slave transfer
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h96);
        ss_n_i = 1'b0;
        tick(4);
        chk("R9 miso_oe selected", miso_oe, 1);
        chk("R9 sck_oe slave", sck_oe, 0);
        got = 8'h00;
        for (int b = 0; b < 8; b++) begin
            mosi_i = v[0];
            mosi_i = (8'h3B >> (7 - b)) & 1;
            tick(8);
            got = {got[6:0], miso_o};
            sck_i = 1'b1;
            tick(8);
            sck_i = 1'b0;
        end
        tick(8);
        ss_n_i = 1'b1;
        tick(1);
        chk("R9 miso released", miso_oe, 0);
        chk("R9 slave sent", got, 8'h96);
        rd(2'd1, v); chk("R9 slave done", v, 8'h80);
        rd(2'd2, v); chk("R9 slave received", v, 8'h3B);
        rd(2'd1, v); chk("R8 slave clear", v, 8'h00);

        // R9 deselected clock edges ignored
        mosi_i = 1'b1;
        for (int b = 0; b < 8; b++) begin
            tick(8); sck_i = 1'b1; tick(8); sck_i = 1'b0;
        end
        tick(8);
        rd(2'd1, v); chk("R9 deselected no flag", v, 8'h00);
        rd(2'd2, v); chk("R9 deselected data kept", v, 8'h3B);

        // R10 abort by enable
        wr(2'd0, 8'h1B);
        preset(8'hAA, 1'b0);
        wr(2'd2, 8'hFF);
        tick(300);
        wr(2'd0, 8'h00);
        tick(2);
        chk("R10 sck low", sck_o, 0);
        chk("R10 sck_oe off", sck_oe, 0);
        tick(1500);
        rd(2'd1, v); chk("R10 no done", v, 8'h00);
        wr(2'd2, 8'h44);
        n = 0;
        for (int k = 0; k < 300; k++) begin
            tick(1);
            if (sck_o) n++;
        end
        chk("R10 no clock while disabled", n, 0);
        wr(2'd0, 8'h03);
        preset(8'h5C, 1'b0);
        wr(2'd2, 8'h81);
        wait_done(v);
        chk("R10 recovered done", v, 8'h80);
        rd(2'd2, v); chk("R10 recovered byte", v, 8'h5C);
        chk("R10 recovered sent", sl_rx, 8'h81);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule